// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Output Compare

This block is a timer peripheral built around a free-running counter that software can read but can never load or reset. The counter advances once per prescaled tick, where the tick is the bus clock divided by 1, 4, 8 or 16. The counter is twice the width of the register bus, so it is read as a high part and a low part. Reading the high part freezes a copy of the low part, which makes the two-part read coherent.

An input-capture channel watches an asynchronous pin. The pin passes through a two-stage synchronizer and then an edge detector. On the edge kind that software selects, the channel copies the current count into a capture register. An output-compare channel watches the count reaching a programmed compare value. On that match it can set, clear or toggle an output pin.

Three events raise sticky flags: capture, compare match and counter wrap. Software clears a flag by writing a one to it. Each flag has a mask bit, and the interrupt request is active while any flag is set together with its mask bit.

Top module: `capcmp_timer`

## Requirements
- R1: The counter starts at zero after reset and advances by exactly one on each prescaled tick. It wraps from all ones to zero. The counter keeps running without interruption.
- R2: Field PRESC (control register at address 6, bits 1:0) selects the tick rate. Code 00 gives one tick per clock, 01 one per 4 clocks, 10 one per 8 clocks and 11 one per 16 clocks. The reset value is 00.
- R3: A tick that takes the counter from all ones to zero sets the wrap flag (flag register at address 8, bit 2) on the same clock edge.
- R4: Field EDGE (control register bits 3:2) selects the capture edge. Code 00 is off, 01 rising, 10 falling and 11 either. Edges of the other kind are ignored. The synchronized pin is compared with its registered previous level, so each pin transition is detected once. The capture happens three clock edges after the pin changes ahead of an edge.
- R5: A detected edge loads the count of that cycle into the capture register (address 2 high, address 3 low). The same edge sets the capture flag, bit 0.
- R6: The compare flag, bit 1, is set on the clock edge where a tick makes the counter equal to the compare register (address 4 high, address 5 low).
- R7: Field PINACT (address 7, bits 1:0) selects what a compare match does to pin `cmp_pin`. Code 00 leaves it as is, 01 toggles it, 10 drives it low and 11 drives it high. The pin stays stable in every cycle without a match. The pin is low after reset.
- R8: Writing a one to a flag bit at address 8 clears that flag. Writing a zero leaves the flag as it is. If a hardware set and a clear fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly while some flag bit and the matching mask bit (address 9, same bit positions) are both one.
- R10: A read of address 0 returns the counter high part and freezes the low part. The next read of address 1 returns the frozen part and releases the freeze. While nothing is frozen, a read of address 1 returns the live low part.
- R11: After reset, the control, pin-action, flag, mask and capture registers read zero. The compare register reads all ones.
- R12: Writes to the counter addresses (0, 1) and the capture addresses (2, 3) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe; has side effects only for addresses 0 and 1 |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for `bus_addr` (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_pin | output | 1 | Compare-driven output pin |
| irq | output | 1 | Interrupt request |

`BUS_W` must be at least 4. The counter is 2*BUS_W bits wide.

## Verification
The bench targets several corner cases, listed here with how a faulty design would show each one:
- The exact wrap period at each prescale code. A wrong divider or a wrap that is missed shifts the measured interval.
- Capture edges of the unselected kind. A detector that ignores polarity sets the capture flag on them.
- A flag clear that lands in the same cycle as a compare match. If the clear wins, the flag is lost.
- The two-part counter read, with a gap between the high and low reads. A design without the freeze returns a low part that has moved on.
- Writes to the counter. A counter that accepts them breaks the elapsed-time arithmetic.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int ADDR_W  = 4;
    localparam int PRE_W   = 4;
    localparam int NFLAG   = 3;

    localparam int FLAG_CAP = 0;
    localparam int FLAG_CMP = 1;
    localparam int FLAG_OVF = 2;

    localparam logic [ADDR_W-1:0] RA_CNT_HI = 4'd0;
    localparam logic [ADDR_W-1:0] RA_CNT_LO = 4'd1;
    localparam logic [ADDR_W-1:0] RA_CAP_HI = 4'd2;
    localparam logic [ADDR_W-1:0] RA_CAP_LO = 4'd3;
    localparam logic [ADDR_W-1:0] RA_CMP_HI = 4'd4;
    localparam logic [ADDR_W-1:0] RA_CMP_LO = 4'd5;
    localparam logic [ADDR_W-1:0] RA_CTRL   = 4'd6;
    localparam logic [ADDR_W-1:0] RA_PINACT = 4'd7;
    localparam logic [ADDR_W-1:0] RA_FLAGS  = 4'd8;
    localparam logic [ADDR_W-1:0] RA_MASK   = 4'd9;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'b00,
        PIN_TOGGLE = 2'b01,
        PIN_LOW    = 2'b10,
        PIN_HIGH   = 2'b11
    } pin_act_e;

    typedef struct packed {
        edge_sel_e   edge_sel;
        logic [1:0]  presc;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic cmp;
        logic cap;
    } flag_vec_t;

    // Mask of prescaler bits that must all be one for a tick.
    function automatic logic [PRE_W-1:0] presc_mask(input logic [1:0] sel);
        case (sel)
            2'b00:   return 4'b0000;
            2'b01:   return 4'b0011;
            2'b10:   return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic edge_hit(input edge_sel_e sel, input logic cur, input logic prev);
        case (sel)
            EDGE_RISE: return cur & ~prev;
            EDGE_FALL: return ~cur & prev;
            EDGE_ANY:  return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic pin_next(input pin_act_e act, input logic cur);
        case (act)
            PIN_TOGGLE: return ~cur;
            PIN_LOW:    return 1'b0;
            PIN_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter
    import cct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       presc_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tick,
    output logic             wrap_evt
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;

    always_comb begin
        pre_mask = presc_mask(presc_sel);
        tick     = ((pre_q & pre_mask) == pre_mask);
        wrap_evt = tick && (cnt_q == {CNT_W{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cct_capture.sv
module cct_capture
    import cct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_in,
    input  edge_sel_e        edge_sel,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_q,
    output logic             cap_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    always_comb begin
        level   = sync_q[SYNC_STAGES-1];
        cap_evt = edge_hit(edge_sel, level, prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            prev_q <= level;
            if (cap_evt) begin
                cap_q <= cnt;
            end
        end
    end

endmodule

// File: rtl/cct_compare.sv
module cct_compare
    import cct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  pin_act_e         pin_act,
    output logic             match_evt,
    output logic             pin_q
);

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt   = cnt + 1'b1;
        match_evt = tick && (cnt_nxt == cmp_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (match_evt) begin
            pin_q <= pin_next(pin_act, pin_q);
        end
    end

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import cct_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cap_pin,
    output logic              cmp_pin,
    output logic              irq
);

    localparam int CNT_W = 2 * BUS_W;

    ctrl_t            ctrl_q;
    pin_act_e         pin_act_q;
    logic [CNT_W-1:0] cmp_q;
    flag_vec_t        flags_q;
    flag_vec_t        mask_q;
    logic [BUS_W-1:0] hold_q;
    logic             hold_vld_q;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic             cnt_tick;
    logic             wrap_evt;
    logic             cap_evt;
    logic             match_evt;

    flag_vec_t        flag_set;
    flag_vec_t        flag_clr;

    logic             rd_cnt_hi;
    logic             rd_cnt_lo;

    cct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .presc_sel (ctrl_q.presc),
        .cnt_q     (cnt_q),
        .tick      (cnt_tick),
        .wrap_evt  (wrap_evt)
    );

    cct_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (cap_pin),
        .edge_sel (ctrl_q.edge_sel),
        .cnt      (cnt_q),
        .cap_q    (cap_q),
        .cap_evt  (cap_evt)
    );

    cct_compare #(.CNT_W(CNT_W)) u_compare (
        .clk       (clk),
        .rst       (rst),
        .cnt       (cnt_q),
        .tick      (cnt_tick),
        .cmp_val   (cmp_q),
        .pin_act   (pin_act_q),
        .match_evt (match_evt),
        .pin_q     (cmp_pin)
    );

    always_comb begin
        rd_cnt_hi    = bus_rd && (bus_addr == RA_CNT_HI);
        rd_cnt_lo    = bus_rd && (bus_addr == RA_CNT_LO);
        flag_set.cap = cap_evt;
        flag_set.cmp = match_evt;
        flag_set.ovf = wrap_evt;
        flag_clr     = (bus_wr && bus_addr == RA_FLAGS) ? flag_vec_t'(bus_wdata[NFLAG-1:0]) : '0;
    end

    // Control, compare and mask registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            pin_act_q <= PIN_KEEP;
            cmp_q     <= '1;
            mask_q    <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                RA_CMP_HI: cmp_q[CNT_W-1:BUS_W] <= bus_wdata;
                RA_CMP_LO: cmp_q[BUS_W-1:0]     <= bus_wdata;
                RA_CTRL:   ctrl_q               <= ctrl_t'(bus_wdata[3:0]);
                RA_PINACT: pin_act_q            <= pin_act_e'(bus_wdata[1:0]);
                RA_MASK:   mask_q               <= flag_vec_t'(bus_wdata[NFLAG-1:0]);
                default:   ;
            endcase
        end
    end

    // Sticky flags: a hardware set overrides a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    // Low-part freeze for coherent counter reads.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
        end else if (rd_cnt_hi) begin
            hold_q     <= cnt_q[BUS_W-1:0];
            hold_vld_q <= 1'b1;
        end else if (rd_cnt_lo) begin
            hold_vld_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            RA_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BUS_W];
            RA_CNT_LO: bus_rdata = hold_vld_q ? hold_q : cnt_q[BUS_W-1:0];
            RA_CAP_HI: bus_rdata = cap_q[CNT_W-1:BUS_W];
            RA_CAP_LO: bus_rdata = cap_q[BUS_W-1:0];
            RA_CMP_HI: bus_rdata = cmp_q[CNT_W-1:BUS_W];
            RA_CMP_LO: bus_rdata = cmp_q[BUS_W-1:0];
            RA_CTRL:   bus_rdata = BUS_W'(ctrl_q);
            RA_PINACT: bus_rdata = BUS_W'(pin_act_q);
            RA_FLAGS:  bus_rdata = BUS_W'(flags_q);
            RA_MASK:   bus_rdata = BUS_W'(mask_q);
            default:   bus_rdata = '0;
        endcase
        irq = |(flags_q & mask_q);
    end

endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             tick,
    input logic [CNT_W-1:0] cmp,
    input logic [2:0]       flags,
    input logic             cap_evt,
    input logic             match_evt,
    input logic [1:0]       pin_act,
    input logic             cmp_pin
);

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == {CNT_W{1'b1}}) |=> flags[2]);

    assert_cap_flag_R5: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> flags[0]);

    assert_cmp_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && CNT_W'(cnt + 1'b1) == cmp) |=> flags[1]);

    assert_pin_high_R7: assert property (@(posedge clk) disable iff (rst)
        (match_evt && pin_act == 2'b11) |=> cmp_pin);

    assert_pin_low_R7: assert property (@(posedge clk) disable iff (rst)
        (match_evt && pin_act == 2'b10) |=> !cmp_pin);

    assert_pin_steady_R7: assert property (@(posedge clk) disable iff (rst)
        !match_evt |=> $stable(cmp_pin));

endmodule

bind capcmp_timer cct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt_q),
    .tick      (cnt_tick),
    .cmp       (cmp_q),
    .flags     (flags_q),
    .cap_evt   (cap_evt),
    .match_evt (match_evt),
    .pin_act   (pin_act_q),
    .cmp_pin   (cmp_pin)
);

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;

    localparam int BW   = 4;
    localparam int CW   = 2 * BW;
    localparam int CMAX = (1 << CW) - 1;
    localparam int LM   = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          b_rd = 1'b0;
    logic          b_wr = 1'b0;
    logic [3:0]    b_addr = '0;
    logic [BW-1:0] b_wdata = '0;
    logic          cap_in = 1'b0;
    logic [BW-1:0] rdata;
    logic          cmp_pin;
    logic          irq;

    always #5 clk = ~clk;

    capcmp_timer #(.BUS_W(BW)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (b_rd),
        .bus_wr    (b_wr),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (rdata),
        .cap_pin   (cap_in),
        .cmp_pin   (cmp_pin),
        .irq       (irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_pre, m_cnt, m_cap, m_cmp, m_ctl, m_pact, m_flags, m_mask;
    int m_pin, m_s1, m_s2, m_prev, m_hold, m_hv;

    function automatic int factor(int s);
        case (s)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return (m_cnt >> BW) & LM;
            1: return m_hv ? m_hold : (m_cnt & LM);
            2: return (m_cap >> BW) & LM;
            3: return m_cap & LM;
            4: return (m_cmp >> BW) & LM;
            5: return m_cmp & LM;
            6: return m_ctl;
            7: return m_pact;
            8: return m_flags;
            9: return m_mask;
            default: return 0;
        endcase
    endfunction

    function automatic string rtag(int a);
        case (a)
            0, 1: return "R10";
            2, 3: return "R5";
            8: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic model_step();
        int mk, es, ev, nxt, scmp, sovf, clr, a, d;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_cap = 0; m_cmp = CMAX; m_ctl = 0; m_pact = 0;
            m_flags = 0; m_mask = 0; m_pin = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_hold = 0; m_hv = 0;
            return;
        end
        a    = int'(b_addr);
        d    = int'(b_wdata);
        mk   = factor(m_ctl & 3) - 1;
        es   = (m_ctl >> 2) & 3;
        ev   = ((es == 1) && m_s2 == 1 && m_prev == 0) ||
               ((es == 2) && m_s2 == 0 && m_prev == 1) ||
               ((es == 3) && m_s2 != m_prev) ? 1 : 0;
        nxt  = (m_cnt + 1) & CMAX;
        scmp = (((m_pre & mk) == mk) && nxt == m_cmp) ? 1 : 0;
        sovf = (((m_pre & mk) == mk) && m_cnt == CMAX) ? 1 : 0;
        clr  = (b_wr && a == 8) ? (d & 7) : 0;
        if (scmp != 0) begin
            if (m_pact == 1) m_pin = 1 - m_pin;
            else if (m_pact == 2) m_pin = 0;
            else if (m_pact == 3) m_pin = 1;
        end
        if (ev != 0) m_cap = m_cnt;
        if (b_rd && a == 0) begin
            m_hold = m_cnt & LM;
            m_hv = 1;
        end else if (b_rd && a == 1) begin
            m_hv = 0;
        end
        if (b_wr) begin
            case (a)
                4: m_cmp = (m_cmp & LM) | (d << BW);
                5: m_cmp = (m_cmp & (LM << BW)) | d;
                6: m_ctl = d & 15;
                7: m_pact = d & 3;
                9: m_mask = d & 7;
                default: ;
            endcase
        end
        m_flags = (m_flags & ~clr & 7) | ev | (scmp << 1) | (sovf << 2);
        if ((m_pre & mk) == mk) m_cnt = nxt;
        m_pre  = (m_pre + 1) & 15;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = int'(cap_in);
    endtask

    always @(posedge clk) begin
        cyc++;
        model_step();
    end

    // Compare outputs against the model on every cycle, away from the edge.
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            check("R9", "irq", int'(irq), ((m_flags & m_mask) != 0) ? 1 : 0);
            check("R7", "cmp_pin", int'(cmp_pin), m_pin);
            if (b_rd) check(rtag(int'(b_addr)), "read data", int'(rdata), m_read(int'(b_addr)));
        end
    end

    // ---------------- bus tasks ----------------
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            b_rd = 1'b0;
            b_wr = 1'b0;
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        b_rd = 1'b0; b_wr = 1'b1; b_addr = 4'(a); b_wdata = BW'(d);
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        b_wr = 1'b0; b_rd = 1'b1; b_addr = 4'(a);
        #1 v = int'(rdata);
    endtask

    task automatic poll_flag(int bitn, output int t);
        int v;
        int n;
        n = 0;
        t = 0;
        do begin
            rd(8, v);
            n++;
        end while (((v >> bitn) & 1) == 0 && n < 5000);
        t = cyc;
        if (n >= 5000) check("R3", "poll timeout", 0, 1);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, v2, t0, t1, p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset values
        check("R11", "cmp_pin after reset", int'(cmp_pin), 0);
        check("R11", "irq after reset", int'(irq), 0);
        rd(6, v); check("R11", "ctrl", v, 0);
        rd(7, v); check("R11", "pin action", v, 0);
        rd(8, v); check("R11", "flags", v, 0);
        rd(9, v); check("R11", "mask", v, 0);
        rd(4, v); check("R11", "cmp hi", v, LM);
        rd(5, v); check("R11", "cmp lo", v, LM);
        rd(2, v); check("R11", "cap hi", v, 0);
        rd(3, v); check("R11", "cap lo", v, 0);
        idle(1);

        // R12 / R1: counter and capture writes ignored, counter keeps stepping
        rd(1, v);
        wr(1, 0);
        rd(1, v2);
        check("R12", "lo advance across write", (v2 - v) & LM, 3);
        wr(0, 5);
        wr(2, 7);
        wr(3, 9);
        rd(2, v); check("R12", "cap hi after write", v, 0);
        rd(3, v); check("R12", "cap lo after write", v, 0);
        idle(1);

        // R10: coherent two-part read
        rd(0, v);
        idle(5);
        rd(1, v);
        rd(1, v2);
        check("R10", "held vs live lo", (v2 - v) & LM, 7);
        idle(1);

        // R2 / R3: wrap period for each prescale code
        for (int s = 0; s < 4; s++) begin
            wr(6, s);
            poll_flag(2, t0);
            wr(8, 4);
            poll_flag(2, t0);
            wr(8, 4);
            poll_flag(2, t1);
            check("R2", $sformatf("wrap period code %0d", s), t1 - t0, (CMAX + 1) * factor(s));
            rd(8, v); check("R3", "wrap flag set", (v >> 2) & 1, 1);
        end
        wr(6, 0);
        wr(8, 7);

        // R4 / R5 / R9: capture on rising edge
        wr(9, 1);
        wr(6, 4);
        wr(8, 1);
        @(negedge clk) cap_in = 1'b1;
        idle(6);
        rd(8, v); check("R5", "capture flag on rise", v & 1, 1);
        check("R9", "irq with capture flag", int'(irq), 1);
        rd(2, v); rd(3, v);
        wr(8, 1);
        rd(8, v); check("R8", "write one clears capture", v & 1, 0);
        check("R9", "irq after clear", int'(irq), 0);
        @(negedge clk) cap_in = 1'b0;
        idle(6);
        rd(8, v); check("R4", "fall ignored with rise code", v & 1, 0);

        // falling select
        wr(6, 8);
        @(negedge clk) cap_in = 1'b1;
        idle(6);
        rd(8, v); check("R4", "rise ignored with fall code", v & 1, 0);
        @(negedge clk) cap_in = 1'b0;
        idle(6);
        rd(8, v); check("R4", "fall captured", v & 1, 1);
        rd(3, v);
        wr(8, 1);

        // either edge
        wr(6, 12);
        @(negedge clk) cap_in = 1'b1;
        idle(6);
        rd(8, v); check("R4", "any-edge rise", v & 1, 1);
        wr(8, 1);
        @(negedge clk) cap_in = 1'b0;
        idle(6);
        rd(8, v); check("R4", "any-edge fall", v & 1, 1);
        wr(8, 1);

        // off
        wr(6, 0);
        @(negedge clk) cap_in = 1'b1;
        idle(6);
        @(negedge clk) cap_in = 1'b0;
        idle(6);
        rd(8, v); check("R4", "capture off", v & 1, 0);
        wr(9, 0);

        // R6 / R7: compare and pin actions
        wr(4, 8);
        wr(5, 0);
        wr(7, 3);
        wr(8, 2);
        idle(300);
        check("R7", "pin driven high", int'(cmp_pin), 1);
        rd(8, v); check("R6", "compare flag", (v >> 1) & 1, 1);
        wr(7, 2);
        idle(300);
        check("R7", "pin driven low", int'(cmp_pin), 0);
        wr(7, 1);
        idle(1);
        p0 = int'(cmp_pin);
        idle(CMAX + 1);
        check("R7", "pin toggled once per period", int'(cmp_pin), 1 - p0);
        wr(7, 0);
        idle(1);
        p0 = int'(cmp_pin);
        idle(300);
        check("R7", "pin kept", int'(cmp_pin), p0);

        // R8: writing zero leaves flags, set wins over clear
        rd(8, v);
        wr(8, 0);
        rd(8, v2);
        check("R8", "write zero keeps flags", v2 & 2, v & 2);
        wr(8, 2);
        poll_flag(1, t0);
        wr(8, 2);
        idle(CMAX + 1 - 4);
        wr(8, 2);
        rd(8, v);
        check("R8", "set wins over same-cycle clear", (v >> 1) & 1, 1);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule